// File: doc/BRIEF.md
# Seconds Counter with Match Alarm

This block is a bus-attached seconds clock. A 32-bit counter advances by one on every cycle in which the tick-enable strobe is high. The strobe comes from an external prescaler and normally pulses once per second. Software can overwrite the counter through a load register. It can also program a 32-bit alarm value. When the counter and the alarm value become equal, a sticky raw alarm flag is set. A one-bit enable gates that flag onto a level interrupt line. Writing any value to the clear register drops the flag.

The slave port is a simple APB-style interface: select, enable and write strobes with a 12-bit byte address. A register write takes effect on the clock edge where select and enable are both high. Read data is combinational from the address. A small bank of identification bytes sits in the last eight words of the 4 KB window. Every other offset outside the register bank reads as zero and ignores writes.

Top module: `rtc_top`

## Requirements
- R1: After reset the counter, alarm value, load shadow, interrupt enable and raw flag all read 0, and `irq` is low.
- R2: Offset 0x00 reads the current count. The count rises by one on each clock edge with `tick_en` high and wraps from 0xFFFFFFFF to 0.
- R3: A write to offset 0x08 replaces the count with the written value, and it takes priority over a tick in the same cycle. Offset 0x08 reads back the last value written there.
- R4: Offset 0x04 holds the 32-bit alarm value as written, and nothing else changes it.
- R5: On any edge with a tick, a write to 0x08 or a write to 0x04, the raw flag (bit 0 of offset 0x14) is set if the resulting count equals the resulting alarm value. Once set, it stays set until cleared.
- R6: A write of any value to offset 0x1C clears the raw flag. If a set condition from R5 occurs on the same edge, the flag stays set.
- R7: A write to offset 0x10 stores only bit 0 of the data as the interrupt enable. The offset reads back that bit with all upper bits 0.
- R8: Offset 0x18 reads raw flag AND enable in bit 0. `irq` equals that value in every cycle.
- R9: Offset 0x0C always reads 1 and ignores writes. Offset 0x1C always reads 0.
- R10: Writes to offsets 0x00, 0x14 and 0x18 change no state.
- R11: Offsets 0xFE0 to 0xFFC read one byte each, zero-extended, in this order: 0x31, 0x10, 0x14, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R12: Word offsets 0x020 to 0xFDC read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle strobe that advances the counter |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase strobe |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address inside the window |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from `paddr` |
| irq | output | 1 | Level interrupt, raw flag AND enable |

## Verification
Two events can coincide on one edge. The first is a clear write to 0x1C in the same cycle that a tick carries the counter onto the alarm value. The second is a load write in the same cycle as a tick. The bench provokes both by raising `tick_en` during the access phase of the write. In the first case the raw flag must still read 1 afterwards, because setting wins. In the second case the count must equal the loaded value, not that value plus one. A bench-side model computes the expected state of every register after each operation, and a full register readback compares against it.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned RTC_DW  = 32;
  localparam int unsigned ID_NUM  = 8;
  localparam int unsigned REG_NUM = 8;

  typedef logic [RTC_DW-1:0] rtc_word_t;

  typedef enum logic [2:0] {
    REG_COUNT  = 3'd0,
    REG_ALARM  = 3'd1,
    REG_LOAD   = 3'd2,
    REG_CTRL   = 3'd3,
    REG_ENABLE = 3'd4,
    REG_RAW    = 3'd5,
    REG_MASKED = 3'd6,
    REG_CLEAR  = 3'd7
  } rtc_reg_e;

  typedef struct packed {
    logic load;
    logic alarm;
    logic enable;
    logic clear;
  } rtc_wr_t;

  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h31;
      3'd1:    return 8'h10;
      3'd2:    return 8'h14;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  function automatic rtc_word_t next_count(input rtc_word_t cur, input logic ld,
                                           input rtc_word_t ld_val, input logic tick);
    if (ld)        return ld_val;
    else if (tick) return cur + rtc_word_t'(1);
    else           return cur;
  endfunction

  function automatic logic alarm_hit(input logic trig, input rtc_word_t cnt,
                                     input rtc_word_t alm);
    return trig && (cnt == alm);
  endfunction
endpackage

// File: rtl/rtc_regif.sv
module rtc_regif
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  rtc_word_t         cnt_q,
  input  rtc_word_t         alm_q,
  input  rtc_word_t         ld_q,
  input  logic              en_q,
  input  logic              raw_q,
  output rtc_wr_t           wr,
  output rtc_word_t         prdata
);
  localparam int unsigned WORD_W  = ADDR_W - 2;
  localparam int unsigned ID_BASE = (1 << WORD_W) - ID_NUM;

  logic [WORD_W-1:0] word;
  logic              acc_wr;
  logic              bank_hit;
  logic              id_hit;
  logic              unused_addr_lo;
  rtc_reg_e          sel;

  assign word           = paddr[ADDR_W-1:2];
  assign unused_addr_lo = ^paddr[1:0];
  assign acc_wr         = psel && penable && pwrite;
  assign bank_hit       = (int'(word) < REG_NUM);
  assign id_hit         = (int'(word) >= ID_BASE);
  assign sel            = rtc_reg_e'(word[2:0]);

  always_comb begin
    wr        = '0;
    if (acc_wr && bank_hit) begin
      wr.load   = (sel == REG_LOAD);
      wr.alarm  = (sel == REG_ALARM);
      wr.enable = (sel == REG_ENABLE);
      wr.clear  = (sel == REG_CLEAR);
    end
  end

  always_comb begin
    prdata = '0;
    if (bank_hit) begin
      case (sel)
        REG_COUNT:  prdata = cnt_q;
        REG_ALARM:  prdata = alm_q;
        REG_LOAD:   prdata = ld_q;
        REG_CTRL:   prdata = rtc_word_t'(1);
        REG_ENABLE: prdata = rtc_word_t'(en_q);
        REG_RAW:    prdata = rtc_word_t'(raw_q);
        REG_MASKED: prdata = rtc_word_t'(raw_q & en_q);
        default:    prdata = '0;
      endcase
    end else if (id_hit) begin
      prdata = rtc_word_t'(id_byte(word[2:0]));
    end
  end
endmodule

// File: rtl/rtc_counter.sv
module rtc_counter
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      ld_wr,
  input  rtc_word_t ld_val,
  output rtc_word_t cnt_q,
  output rtc_word_t cnt_nxt,
  output rtc_word_t ld_q
);
  assign cnt_nxt = next_count(cnt_q, ld_wr, ld_val, tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ld_q  <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (ld_wr) ld_q <= ld_val;
    end
  end
endmodule

// File: rtl/rtc_match.sv
module rtc_match
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      ld_wr,
  input  logic      alm_wr,
  input  rtc_word_t wdata,
  input  rtc_word_t cnt_nxt,
  output rtc_word_t alm_q,
  output logic      hit
);
  rtc_word_t alm_nxt;

  assign alm_nxt = alm_wr ? wdata : alm_q;
  assign hit     = alarm_hit(tick | ld_wr | alm_wr, cnt_nxt, alm_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alm_q <= '0;
    else        alm_q <= alm_nxt;
  end
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic clr_wr,
  input  logic en_wr,
  input  logic en_bit,
  output logic raw_q,
  output logic en_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      if (hit)         raw_q <= 1'b1;
      else if (clr_wr) raw_q <= 1'b0;
      if (en_wr)       en_q  <= en_bit;
    end
  end

  assign irq = raw_q & en_q;
endmodule

// File: rtl/rtc_top.sv
module rtc_top
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [RTC_DW-1:0] pwdata,
  output logic [RTC_DW-1:0] prdata,
  output logic              irq
);
  rtc_wr_t   wr_s;
  rtc_word_t cnt_q;
  rtc_word_t cnt_nxt;
  rtc_word_t ld_q;
  rtc_word_t alm_q;
  logic      raw_q;
  logic      en_q;

  logic ev_ld_wr;
  logic ev_alm_wr;
  logic ev_clr_wr;
  logic ev_hit;

  assign ev_ld_wr  = wr_s.load;
  assign ev_alm_wr = wr_s.alarm;
  assign ev_clr_wr = wr_s.clear;

  rtc_regif #(.ADDR_W(ADDR_W)) u_regif (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .cnt_q(cnt_q), .alm_q(alm_q), .ld_q(ld_q), .en_q(en_q), .raw_q(raw_q),
    .wr(wr_s), .prdata(prdata)
  );

  rtc_counter u_counter (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .ld_wr(ev_ld_wr), .ld_val(pwdata),
    .cnt_q(cnt_q), .cnt_nxt(cnt_nxt), .ld_q(ld_q)
  );

  rtc_match u_match (
    .clk(clk), .rst_n(rst_n), .tick(tick_en), .ld_wr(ev_ld_wr), .alm_wr(ev_alm_wr),
    .wdata(pwdata), .cnt_nxt(cnt_nxt), .alm_q(alm_q), .hit(ev_hit)
  );

  rtc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .hit(ev_hit), .clr_wr(ev_clr_wr),
    .en_wr(wr_s.enable), .en_bit(pwdata[0]),
    .raw_q(raw_q), .en_q(en_q), .irq(irq)
  );
endmodule

// File: rtl/rtc_chk.sv
module rtc_chk
  import rtc_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic              psel,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [RTC_DW-1:0] pwdata,
  input logic [RTC_DW-1:0] prdata,
  input logic              irq,
  input rtc_word_t         cnt_q,
  input rtc_word_t         alm_q,
  input logic              raw_q,
  input logic              ev_ld_wr,
  input logic              ev_alm_wr,
  input logic              ev_clr_wr,
  input logic              ev_hit
);
  logic [ADDR_W-3:0] word;
  assign word = paddr[ADDR_W-1:2];

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en && !ev_ld_wr |=> cnt_q == $past(cnt_q) + rtc_word_t'(1)); // R2
  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ld_wr |=> cnt_q == $past(pwdata)); // R3
  AST_ALARM_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_alm_wr |=> $stable(alm_q)); // R4
  AST_RAW_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    raw_q && !ev_clr_wr |=> raw_q); // R5
  AST_RAW_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_q) |-> $past(ev_hit)); // R5
  AST_LOAD_EQ_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    ev_ld_wr && !ev_alm_wr && (pwdata == alm_q) |=> raw_q); // R5
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_clr_wr && !ev_hit |=> !raw_q); // R6
  AST_IRQ_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
    psel && !pwrite && (int'(word) == 6) |-> prdata[0] == irq); // R8
  AST_CTRL_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    psel && !pwrite && (int'(word) == 3) |-> prdata == 32'd1); // R9
endmodule

bind rtc_top rtc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq),
  .cnt_q(cnt_q), .alm_q(alm_q), .raw_q(raw_q),
  .ev_ld_wr(ev_ld_wr), .ev_alm_wr(ev_alm_wr), .ev_clr_wr(ev_clr_wr), .ev_hit(ev_hit)
);

// File: tb/rtc_top_tb.sv
module rtc_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        psel = 1'b0;
  logic        penable = 1'b0;
  logic        pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int total = 0;
  int bad = 0;

  logic [31:0] m_cnt = 0, m_alm = 0, m_ld = 0;
  logic        m_en = 0, m_raw = 0;

  always #4 clk = ~clk;

  rtc_top u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .irq(irq)
  );

  function automatic logic [31:0] id_exp(input int i);
    logic [7:0] t [8] = '{8'h31, 8'h10, 8'h14, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return {24'h0, t[i]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic model_step(input logic [11:0] a, input logic [31:0] d,
                            input bit is_wr, input bit tk);
    logic [9:0]  w = a[11:2];
    bit          ld = is_wr && w == 2;
    bit          aw = is_wr && w == 1;
    bit          cl = is_wr && w == 7;
    logic [31:0] nc = ld ? d : (tk ? m_cnt + 1 : m_cnt);
    logic [31:0] na = aw ? d : m_alm;
    if ((ld || aw || tk) && nc == na) m_raw = 1;
    else if (cl) m_raw = 0;
    if (ld) m_ld = d;
    if (is_wr && w == 4) m_en = d[0];
    m_cnt = nc;
    m_alm = na;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 1; pwrite = 0; paddr = a;
    #1 d = prdata;
    psel = 0; penable = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input bit tk);
    @(negedge clk);
    psel = 1; pwrite = 1; penable = 0; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1; tick_en = tk;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0; tick_en = 0;
    model_step(a, d, 1, tk);
  endtask

  task automatic tick1();
    @(negedge clk);
    tick_en = 1;
    @(negedge clk);
    tick_en = 0;
    model_step(12'h0, 32'h0, 0, 1);
  endtask

  task automatic check_all(input string ctx);
    logic [31:0] v;
    rd(12'h000, v); chk({ctx, " R2 count"}, v, m_cnt);
    rd(12'h004, v); chk({ctx, " R4 alarm"}, v, m_alm);
    rd(12'h008, v); chk({ctx, " R3 load"}, v, m_ld);
    rd(12'h00C, v); chk({ctx, " R9 ctrl"}, v, 32'd1);
    rd(12'h010, v); chk({ctx, " R7 enable"}, v, {31'h0, m_en});
    rd(12'h014, v); chk({ctx, " R5 raw"}, v, {31'h0, m_raw});
    rd(12'h018, v); chk({ctx, " R8 masked"}, v, {31'h0, m_raw & m_en});
    rd(12'h01C, v); chk({ctx, " R9 clear_rd"}, v, 32'd0);
    @(negedge clk); #1 chk({ctx, " R8 irq"}, {31'h0, irq}, {31'h0, m_raw & m_en});
  endtask

  initial begin
    #(8 * 200000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check_all("R1 reset");

    for (int i = 0; i < 8; i++) begin
      rd(12'hFE0 + 12'(i * 4), v);
      chk($sformatf("R11 id[%0d]", i), v, id_exp(i));
    end

    for (int w = 8; w < 1016; w++) begin
      rd(12'(w * 4), v);
      chk($sformatf("R12 read word %0d", w), v, 32'd0);
    end
    for (int w = 8; w < 1016; w += 37) wr(12'(w * 4), 32'hFFFF_FFFF, 0);
    check_all("R12 unmapped writes");

    wr(12'h010, 32'hFFFF_FFFE, 0); check_all("R7 enable bit0 clear");
    wr(12'h010, 32'h0000_0003, 0); check_all("R7 enable bit0 set");

    wr(12'h008, 32'h1234_5678, 0); check_all("R3 load");
    tick1(); tick1(); check_all("R2 two ticks");
    wr(12'h008, 32'hFFFF_FFFE, 0);
    wr(12'h004, 32'h0000_0000, 0);
    tick1(); check_all("R2 before wrap");
    tick1(); check_all("R2 R5 wrap hits alarm");
    wr(12'h01C, 32'h0, 0); check_all("R6 clear with zero");

    for (int mode = 0; mode < 3; mode++) begin
      for (int d = 0; d < 5; d++) begin
        logic [31:0] base = 32'h0100_0000 * 32'(mode + 1) + 32'(d * 16);
        wr(12'h01C, 32'hA5A5_0000 + 32'(d), 0);
        wr(12'h008, base, 0);
        if (mode == 0) begin
          wr(12'h004, base + 32'(d), 0);
          check_all($sformatf("R5 arm d=%0d", d));
          for (int k = 0; k < d; k++) begin
            tick1();
            check_all($sformatf("R5 tick k=%0d d=%0d", k, d));
          end
        end else if (mode == 1) begin
          wr(12'h004, base + 32'(d), 0);
          wr(12'h008, base + 32'(d), 0);
          check_all($sformatf("R3 R5 load equal d=%0d", d));
        end else begin
          wr(12'h004, base, 0);
          check_all($sformatf("R4 R5 alarm equal d=%0d", d));
        end
      end
    end

    wr(12'h01C, 32'h1, 0);
    wr(12'h008, 32'h0000_0100, 0);
    wr(12'h004, 32'h0000_0101, 0);
    check_all("R6 before collision");
    wr(12'h01C, 32'h1, 1);
    check_all("R6 clear vs tick hit, set wins");
    wr(12'h01C, 32'h1, 0);
    check_all("R6 clear after collision");

    wr(12'h008, 32'h0000_0500, 1);
    check_all("R3 load beats tick");

    wr(12'h004, 32'h0000_0501, 0);
    tick1();
    wr(12'h010, 32'h0, 0); check_all("R8 raw set, enable off");
    wr(12'h010, 32'h1, 0); check_all("R8 raw set, enable on");

    wr(12'h000, 32'hDEAD_BEEF, 0); check_all("R10 write count offset");
    wr(12'h014, 32'h0, 0);         check_all("R10 write raw offset");
    wr(12'h018, 32'h0, 0);         check_all("R10 write masked offset");
    wr(12'h00C, 32'h0, 0);         check_all("R9 write ctrl");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule